// File: doc/BRIEF.md
# Fractional audio master clock divider

This block derives an audio master clock from a faster system clock using a rational ratio M/D, where the multiplier M and the divisor D are written through a small register-style port. Each field is written as its value minus one. The output is meant to run at 256 times the audio sample rate. For example, a 180 MHz input with M = 32 and D = 225 averages 25.6 MHz, which corresponds to a 100 kHz sample rate.

A phase accumulator adds 2·M on every input cycle. Each time the sum reaches D, the accumulator subtracts D and the output toggles. When D is not a multiple of M, the output period moves between the two nearest whole numbers of input cycles, and only the long-run average is exact.

Software may write a new ratio while the output is running. A legal write is held as a pending ratio and raises a busy flag. The pending ratio is copied to the active ratio at the next output toggle, and the accumulator is cleared at the same time. The busy flag falls a fixed four cycles later, so software polls it until it reads 0. A write whose multiplier field exceeds its divisor field is discarded. The ratio M = D is a bypass case, in which the input clock is passed straight to the output.

Top module: `mclk_frac_div`

## Requirements
- R1: When rst is 1 at a rising clock edge, the following state holds after that edge: mclk_out is 0, busy is 0, and the active ratio is 1/1. After reset is released, mclk_out therefore follows clk.
- R2: mult_m1 is 8 bits and div_m1 is 12 bits. The ratio they encode is (mult_m1+1)/(div_m1+1). When 2·(mult_m1+1) ≤ div_m1+1, the number of rising edges of mclk_out in any window of N input cycles is within ±1 of N·(mult_m1+1)/(div_m1+1).
- R3: A write with mult_m1 > div_m1 is discarded. The active ratio, the output frequency and busy are all left unchanged.
- R4: A legal write (mult_m1 ≤ div_m1) makes busy read 1 from the cycle after the write.
- R5: A pending ratio does not take effect until the next output toggle. When the active ratio is a bypass ratio, it takes effect on the next cycle. The accumulator is cleared when the new ratio is loaded.
- R6: After a pending ratio is loaded, busy stays 1 for exactly 4 more cycles and then falls. A legal write therefore keeps busy at 1 for at least 5 cycles.
- R7: When mult_m1 = div_m1, mclk_out equals clk, giving one rising edge per input cycle.
- R8: When the ratio is above one half but below one, the output toggles on every input cycle, so its frequency is exactly half the input frequency.
- R9: When the ratio is not the reciprocal of an integer, every rising-to-rising period of mclk_out is either the floor or the ceiling of (div_m1+1)/(mult_m1+1) input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a new ratio |
| wr_mult_m1 | input | 8 | Multiplier minus one |
| wr_div_m1 | input | 12 | Divisor minus one |
| mclk_out | output | 1 | Divided master clock |
| busy | output | 1 | Ratio update in progress |

## Verification
The hardest state to reach from the ports is a pending ratio that is still waiting for a toggle long after the write. When the active ratio is fast, the swap happens within a few cycles and cannot be told apart from an immediate load. The stimulus therefore first loads the slowest ratio, 1/4096. It waits for busy to clear, which fixes the accumulator phase at zero, so the next toggle is known to be about 2048 cycles away. It then writes a new ratio and checks that busy is still 1 a thousand cycles later. The clamp, exact-half and bypass ratios are each driven from the vector table, and each is measured by counting rising edges over a long window.

// File: rtl/mclk_frac_pkg.sv
package mclk_frac_pkg;
  localparam int MULT_W_DEF = 8;
  localparam int DIV_W_DEF  = 12;
  localparam int SYNC_DEF   = 4;

  typedef enum logic [1:0] {
    MODE_DIV    = 2'd0,
    MODE_CLAMP  = 2'd1,
    MODE_BYPASS = 2'd2
  } mode_e;
endpackage

// File: rtl/mclk_ratio_regs.sv
module mclk_ratio_regs
  import mclk_frac_pkg::*;
#(
  parameter int MULT_W = MULT_W_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int SYNC_CYC = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MULT_W-1:0] wr_mult_m1,
  input  logic [DIV_W-1:0]  wr_div_m1,
  input  logic              tgl,
  output logic [MULT_W-1:0] act_mult_m1,
  output logic [DIV_W-1:0]  act_div_m1,
  output mode_e             mode,
  output logic              load,
  output logic              busy
);
  localparam int CMP_W = ((DIV_W > MULT_W) ? DIV_W : MULT_W) + 2;
  localparam int CNT_W = $clog2(SYNC_CYC + 1);

  logic [MULT_W-1:0] pend_mult_m1;
  logic [DIV_W-1:0]  pend_div_m1;
  logic              pend_v;
  logic [CNT_W-1:0]  sync_cnt;
  logic              wr_ok;
  logic [CMP_W-1:0]  step_x, den_x;

  assign wr_ok = wr_en && (CMP_W'(wr_mult_m1) <= CMP_W'(wr_div_m1));

  // Operating mode of the active ratio
  assign step_x = (CMP_W'(act_mult_m1) + CMP_W'(1)) << 1;
  assign den_x  = CMP_W'(act_div_m1) + CMP_W'(1);

  always_comb begin
    if (CMP_W'(act_mult_m1) == CMP_W'(act_div_m1)) mode = MODE_BYPASS;
    else if (step_x > den_x)                       mode = MODE_CLAMP;
    else                                           mode = MODE_DIV;
  end

  assign load = !rst && pend_v && (tgl || (mode == MODE_BYPASS));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mult_m1  <= '0;
      act_div_m1   <= '0;
      pend_mult_m1 <= '0;
      pend_div_m1  <= '0;
      pend_v       <= 1'b0;
      sync_cnt     <= '0;
      busy         <= 1'b0;
    end else begin
      if (load) begin
        act_mult_m1 <= pend_mult_m1;
        act_div_m1  <= pend_div_m1;
        pend_v      <= 1'b0;
        sync_cnt    <= CNT_W'(SYNC_CYC);
      end else if (sync_cnt != '0) begin
        sync_cnt <= sync_cnt - CNT_W'(1);
        if (sync_cnt == CNT_W'(1) && !pend_v) busy <= 1'b0;
      end
      if (wr_ok) begin
        pend_mult_m1 <= wr_mult_m1;
        pend_div_m1  <= wr_div_m1;
        pend_v       <= 1'b1;
        busy         <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mclk_phase_acc.sv
module mclk_phase_acc
  import mclk_frac_pkg::*;
#(
  parameter int MULT_W = MULT_W_DEF,
  parameter int DIV_W  = DIV_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] mult_m1,
  input  logic [DIV_W-1:0]  div_m1,
  input  mode_e             mode,
  input  logic              load,
  output logic              tgl,
  output logic              div_q
);
  localparam int BASE_W = ((DIV_W + 1) > (MULT_W + 2)) ? (DIV_W + 1) : (MULT_W + 2);
  localparam int SUM_W  = BASE_W + 1;

  logic [SUM_W-1:0] acc, step, den, sum;

  assign step = (SUM_W'(mult_m1) + SUM_W'(1)) << 1;
  assign den  = SUM_W'(div_m1) + SUM_W'(1);
  assign sum  = acc + step;

  always_comb begin
    case (mode)
      MODE_CLAMP: tgl = 1'b1;
      MODE_DIV:   tgl = (sum >= den);
      default:    tgl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      div_q <= 1'b0;
    end else begin
      if (tgl) div_q <= ~div_q;
      if (load || mode != MODE_DIV) acc <= '0;
      else if (sum >= den)          acc <= sum - den;
      else                          acc <= sum;
    end
  end
endmodule

// File: rtl/mclk_out_sel.sv
module mclk_out_sel
  import mclk_frac_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  div_q,
  output logic  mclk_out
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  assign mclk_out = run_q && ((mode == MODE_BYPASS) ? clk : div_q);
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
  import mclk_frac_pkg::*;
#(
  parameter int MULT_W   = MULT_W_DEF,
  parameter int DIV_W    = DIV_W_DEF,
  parameter int SYNC_CYC = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MULT_W-1:0] wr_mult_m1,
  input  logic [DIV_W-1:0]  wr_div_m1,
  output logic              mclk_out,
  output logic              busy
);
  logic [MULT_W-1:0] act_mult_m1;
  logic [DIV_W-1:0]  act_div_m1;
  mode_e             mode;
  logic              load, tgl, div_q;

  mclk_ratio_regs #(.MULT_W(MULT_W), .DIV_W(DIV_W), .SYNC_CYC(SYNC_CYC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mult_m1(wr_mult_m1),
    .wr_div_m1(wr_div_m1), .tgl(tgl), .act_mult_m1(act_mult_m1),
    .act_div_m1(act_div_m1), .mode(mode), .load(load), .busy(busy)
  );

  mclk_phase_acc #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_acc (
    .clk(clk), .rst(rst), .mult_m1(act_mult_m1), .div_m1(act_div_m1),
    .mode(mode), .load(load), .tgl(tgl), .div_q(div_q)
  );

  mclk_out_sel u_sel (
    .clk(clk), .rst(rst), .mode(mode), .div_q(div_q), .mclk_out(mclk_out)
  );
endmodule

// File: rtl/mclk_frac_chk.sv
module mclk_frac_chk #(
  parameter int MULT_W = 8,
  parameter int DIV_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [MULT_W-1:0] wr_mult_m1,
  input logic [DIV_W-1:0]  wr_div_m1,
  input logic              busy,
  input logic              load,
  input logic [MULT_W-1:0] act_mult_m1,
  input logic [DIV_W-1:0]  act_div_m1,
  input logic              div_q
);
  localparam int CMP_W = ((DIV_W > MULT_W) ? DIV_W : MULT_W) + 1;

  logic legal_wr;
  assign legal_wr = CMP_W'(wr_mult_m1) <= CMP_W'(wr_div_m1);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (act_mult_m1 == '0 && act_div_m1 == '0 && !busy && !div_q));

  p_active_legal_r2: assert property (@(posedge clk) disable iff (rst)
    CMP_W'(act_mult_m1) <= CMP_W'(act_div_m1));

  p_illegal_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !legal_wr && !busy) |=>
      (!busy && $stable(act_mult_m1) && $stable(act_div_m1)));

  p_busy_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && legal_wr) |=> busy);

  p_busy_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(load, 5));
endmodule

bind mclk_frac_div mclk_frac_chk #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mult_m1(wr_mult_m1),
  .wr_div_m1(wr_div_m1), .busy(busy), .load(load),
  .act_mult_m1(act_mult_m1), .act_div_m1(act_div_m1), .div_q(div_q)
);

// File: tb/tb_mclk_frac_div.sv
module tb_mclk_frac_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_mult_m1 = '0;
  logic [11:0] wr_div_m1 = '0;
  logic        mclk_out, busy;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  bit done = 0;

  localparam int NWIN = 12000;
  localparam int NVEC = 9;
  // {mult_m1, div_m1}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'd31,  12'd224},   // 32/225
    {8'd2,   12'd9},     // 3/10
    {8'd0,   12'd4095},  // 1/4096
    {8'd255, 12'd4095},  // 256/4096
    {8'd127, 12'd255},   // exact half
    {8'd199, 12'd255},   // clamp
    {8'd1,   12'd2},     // 2/3 clamp
    {8'd0,   12'd0},     // bypass
    {8'd223, 12'd1574}   // 224/1575
  };

  always #2 clk = ~clk;

  mclk_frac_div dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mult_m1(wr_mult_m1),
    .wr_div_m1(wr_div_m1), .mclk_out(mclk_out), .busy(busy)
  );

  always @(posedge mclk_out) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_ratio(input logic [7:0] m, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mult_m1 = m; wr_div_m1 = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic count_window(input int n, output int cnt);
    int start;
    @(negedge clk);
    start = edge_cnt;
    repeat (n) @(negedge clk);
    cnt = edge_cnt - start;
  endtask

  task automatic measure_periods(output int pmin, output int pmax);
    logic prev;
    int guard;
    pmin = 1 << 30; pmax = 0;
    @(negedge clk); prev = mclk_out; guard = 0;
    while (!( !prev && mclk_out) && guard < 5000) begin
      prev = mclk_out; @(negedge clk); guard++;
    end
    for (int k = 0; k < 6; k++) begin
      int c;
      c = 0;
      do begin
        prev = mclk_out; @(negedge clk); c++;
      end while (!(!prev && mclk_out) && c < 5000);
      if (c < pmin) pmin = c;
      if (c > pmax) pmax = c;
    end
  endtask

  function automatic bit near(input int act, input real e);
    real diff;
    diff = real'(act) - e;
    return (diff <= 1.0) && (diff >= -1.0);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt, cyc, pmin, pmax, m, d;
    real e;
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    chk(mclk_out == 1'b0, "R1 mclk_out low in reset", int'(mclk_out), 0);
    chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
    @(negedge clk); rst = 1'b0;
    count_window(2000, cnt);
    chk(near(cnt, 2000.0), "R1 ratio 1/1 after reset", cnt, 2000);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      m = int'(VEC[v][19:12]) + 1;
      d = int'(VEC[v][11:0]) + 1;
      write_ratio(VEC[v][19:12], VEC[v][11:0]);
      chk(busy == 1'b1, "R4 busy after legal write", int'(busy), 1);
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R6 busy held 5 cycles", int'(busy), 1);
      wait_idle(cyc);
      chk(busy == 1'b0, "R6 busy clears", int'(busy), 0);
      count_window(NWIN, cnt);
      if (m == d) begin
        e = real'(NWIN);
        chk(near(cnt, e), "R7 bypass edge count", cnt, $rtoi(e));
      end else if (2 * m > d) begin
        e = real'(NWIN) / 2.0;
        chk(near(cnt, e), "R8 clamp edge count", cnt, $rtoi(e));
      end else begin
        e = real'(NWIN) * real'(m) / real'(d);
        chk(near(cnt, e), "R2 edge count", cnt, $rtoi(e));
        if ((d % m) != 0 && d / m <= 64) begin
          measure_periods(pmin, pmax);
          chk(pmin >= d / m, "R9 min period", pmin, d / m);
          chk(pmax <= d / m + 1, "R9 max period", pmax, d / m + 1);
        end
      end
    end

    // R3: illegal write ignored (active 224/1575)
    write_ratio(8'd10, 12'd5);
    chk(busy == 1'b0, "R3 busy stays low", int'(busy), 0);
    count_window(NWIN, cnt);
    e = real'(NWIN) * 224.0 / 1575.0;
    chk(near(cnt, e), "R3 ratio unchanged", cnt, $rtoi(e));

    // R5: new ratio waits for the next toggle
    write_ratio(8'd0, 12'd4095);
    wait_idle(cyc);
    write_ratio(8'd31, 12'd224);
    repeat (1000) @(negedge clk);
    chk(busy == 1'b1, "R5 pending until toggle", int'(busy), 1);
    wait_idle(cyc);
    chk(busy == 1'b0, "R5 applied after toggle", int'(busy), 0);
    count_window(4500, cnt);
    e = 4500.0 * 32.0 / 225.0;
    chk(near(cnt, e), "R5 new ratio active", cnt, $rtoi(e));

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(mclk_out == 1'b0, "R1 mclk_out low on re-reset", int'(mclk_out), 0);
    chk(busy == 1'b0, "R1 busy low on re-reset", int'(busy), 0);
    @(negedge clk); rst = 1'b0;
    count_window(1000, cnt);
    chk(near(cnt, 1000.0), "R1 ratio 1/1 after re-reset", cnt, 1000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule